// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns one memory reference into a 20-bit physical address. It first forms a 16-bit effective offset from the selected addressing mode. The offset can come from a direct operand, from a single pointer register, or from a base register, an index register and a displacement in several combinations. For an instruction fetch it is simply the instruction pointer. The block then picks one of four segment registers: code, data, stack or extra. The choice follows the access type and the base register, and a segment-override prefix can replace it. Finally the block shifts the segment value left by four bits and adds the offset.

A reference enters on a valid/ready input handshake. All operand values ride along with it. The result leaves on a valid/ready output handshake that carries the offset, the chosen segment code, the segment value and the physical address. With `OUT_REG=1` (the default) one register stage sits between the two sides, so the block can accept a new reference every cycle. When the consumer holds `out_ready` low, the held result stays put and `in_ready` drops in the same cycle, so an upstream stage sees back-pressure at once. With `OUT_REG=0` the path is purely combinational: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`.

Top module: `seg_addr_gen`

## Requirements
- R1: The physical address equals (segment value × 16 + effective offset) modulo 2^20.
- R2: When `acc`=0 (instruction fetch), the offset is `ip` and the segment is code (`seg_id`=1). `mode`, the displacement and the override are ignored.
- R3: Mode code 1 is register-indirect. `ptr_sel` picks the offset: 0=BX, 1=BP, 2=SI, 3=DI. Mode 0 is direct: the offset is the full 16-bit `disp`, whatever `disp_kind` holds.
- R4: Mode 2 adds the base register (`base_sel` 0=BX, 1=BP) to the displacement. Mode 3 adds the index register (`idx_sel` 0=SI, 1=DI) to the displacement. Mode 4 adds base, index and displacement. `disp_kind` selects the displacement: 0=none, 1=`disp[7:0]` sign-extended, 2 or 3=the full 16 bits.
- R5: Effective-offset sums wrap modulo 2^16.
- R6: With no override, a data access (`acc`=1) uses the data segment (`seg_id`=3). It uses the stack segment (`seg_id`=2) instead when BP is the base, meaning mode 1 with `ptr_sel`=1, or mode 2 or 4 with `base_sel`=1. A stack access (`acc`=2) uses the stack segment.
- R7: For data and stack accesses, `ovr_en`=1 selects the segment named by `ovr_seg`: 0=extra, 1=code, 2=stack, 3=data. `seg_id` reports the same code and `seg_val` the matching register.
- R8: Mode codes 5 to 7 behave as direct mode. Access type 3 behaves as a data access.
- R9: With `OUT_REG=1`, a reference accepted at a clock edge appears on the outputs after that edge. While `out_valid`=1 and `out_ready`=0, the outputs hold and `in_ready` is 0. Otherwise `in_ready` is 1.
- R10: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A reference is presented |
| in_ready | output | 1 | Block accepts the reference this cycle |
| seg_cs | input | 16 | Code segment value |
| seg_ds | input | 16 | Data segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_es | input | 16 | Extra segment value |
| reg_bx | input | 16 | BX pointer value |
| reg_bp | input | 16 | BP pointer value |
| reg_si | input | 16 | SI pointer value |
| reg_di | input | 16 | DI pointer value |
| ip | input | 16 | Instruction pointer |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Register-indirect pointer select |
| base_sel | input | 1 | Base register select |
| idx_sel | input | 1 | Index register select |
| disp | input | 16 | Displacement or direct operand |
| disp_kind | input | 2 | Displacement size code |
| acc | input | 2 | Access type: 0 fetch, 1 data, 2 stack |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| eff_ofs | output | 16 | Effective offset |
| seg_id | output | 2 | Chosen segment code (0 ES, 1 CS, 2 SS, 3 DS) |
| seg_val | output | 16 | Chosen segment value |
| phys | output | 20 | Physical address |

## Verification
Every result of an accepted reference — offset, segment code, segment value and physical address — is due together, one clock edge after acceptance. The bench drives inputs on the falling edge and samples on the following falling edge, half a cycle after the capturing edge. `in_ready` responds to `out_ready` in the same cycle and is sampled before the next edge. In the stall test the held outputs are re-sampled after an extra edge with `out_ready` low, and the queued reference is checked one edge after `out_ready` returns.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  localparam logic [2:0] AM_DIRECT  = 3'd0;
  localparam logic [2:0] AM_PTR     = 3'd1;
  localparam logic [2:0] AM_BASED   = 3'd2;
  localparam logic [2:0] AM_INDEXED = 3'd3;
  localparam logic [2:0] AM_BIDX    = 3'd4;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_DATA  = 2'd1;
  localparam logic [1:0] ACC_STACK = 2'd2;

  localparam logic [1:0] DK_NONE  = 2'd0;
  localparam logic [1:0] DK_SHORT = 2'd1;

  localparam logic [1:0] PTR_BP = 2'd1;

  typedef enum logic [1:0] {
    SG_ES = 2'd0,
    SG_CS = 2'd1,
    SG_SS = 2'd2,
    SG_DS = 2'd3
  } seg_id_t;

  localparam int NUM_SEGS = 4;
endpackage

// File: rtl/agu_offset.sv
module agu_offset
  import seg_agu_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int SDISP_W = 8
) (
  input  logic [1:0]       acc,
  input  logic [2:0]       mode,
  input  logic [1:0]       ptr_sel,
  input  logic             base_sel,
  input  logic             idx_sel,
  input  logic [OFS_W-1:0] bx,
  input  logic [OFS_W-1:0] bp,
  input  logic [OFS_W-1:0] si,
  input  logic [OFS_W-1:0] di,
  input  logic [OFS_W-1:0] ip,
  input  logic [OFS_W-1:0] disp,
  input  logic [1:0]       disp_kind,
  output logic [OFS_W-1:0] ofs,
  output logic             bp_base
);
  localparam int EXT_W = OFS_W - SDISP_W;

  logic [OFS_W-1:0] base_v, idx_v, ptr_v, dsp, mode_ofs;
  logic             bp_m;

  always_comb begin
    base_v = base_sel ? bp : bx;
    idx_v  = idx_sel ? di : si;
    case (ptr_sel)
      2'd0:    ptr_v = bx;
      2'd1:    ptr_v = bp;
      2'd2:    ptr_v = si;
      default: ptr_v = di;
    endcase
  end

  always_comb begin
    case (disp_kind)
      DK_NONE:  dsp = '0;
      DK_SHORT: dsp = {{EXT_W{disp[SDISP_W-1]}}, disp[SDISP_W-1:0]};
      default:  dsp = disp;
    endcase
  end

  always_comb begin
    mode_ofs = disp;
    bp_m     = 1'b0;
    case (mode)
      AM_PTR: begin
        mode_ofs = ptr_v;
        bp_m     = (ptr_sel == PTR_BP);
      end
      AM_BASED: begin
        mode_ofs = base_v + dsp;
        bp_m     = base_sel;
      end
      AM_INDEXED: begin
        mode_ofs = idx_v + dsp;
      end
      AM_BIDX: begin
        mode_ofs = base_v + idx_v + dsp;
        bp_m     = base_sel;
      end
      default: begin
        mode_ofs = disp;
      end
    endcase
  end

  assign ofs     = (acc == ACC_FETCH) ? ip : mode_ofs;
  assign bp_base = bp_m;
endmodule

// File: rtl/agu_segsel.sv
module agu_segsel
  import seg_agu_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [1:0]       acc,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_seg,
  input  logic             bp_base,
  input  logic [SEG_W-1:0] seg_es,
  input  logic [SEG_W-1:0] seg_cs,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_ds,
  output logic [1:0]       seg_id,
  output logic [SEG_W-1:0] seg_val
);
  logic [SEG_W-1:0] bank [NUM_SEGS];
  seg_id_t          pick;

  assign bank[SG_ES] = seg_es;
  assign bank[SG_CS] = seg_cs;
  assign bank[SG_SS] = seg_ss;
  assign bank[SG_DS] = seg_ds;

  always_comb begin
    if (acc == ACC_FETCH)
      pick = SG_CS;
    else if (ovr_en)
      pick = seg_id_t'(ovr_seg);
    else if (acc == ACC_STACK || bp_base)
      pick = SG_SS;
    else
      pick = SG_DS;
  end

  assign seg_id  = pick;
  assign seg_val = bank[pick];
endmodule

// File: rtl/agu_combine.sv
module agu_combine #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4
) (
  input  logic [SEG_W-1:0]       seg_val,
  input  logic [OFS_W-1:0]       ofs,
  output logic [SEG_W+SHIFT-1:0] phys
);
  localparam int PA_W  = SEG_W + SHIFT;
  localparam int PAD_W = PA_W - OFS_W;

  logic [PA_W-1:0] seg_sh, ofs_ext;

  assign seg_sh  = {seg_val, {SHIFT{1'b0}}};
  assign ofs_ext = {{PAD_W{1'b0}}, ofs};
  assign phys    = seg_sh + ofs_ext;
endmodule

// File: rtl/agu_outreg.sv
module agu_outreg #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (OUT_REG) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;
      logic         take;

      assign in_ready = !vld_q || out_ready;
      assign take     = in_valid && in_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (take) dat_q <= in_data;
        end
      end

      assign out_valid = vld_q;
      assign out_data  = dat_q;
    end else begin : g_pass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W   = 16,
  parameter int OFS_W   = 16,
  parameter int SHIFT   = 4,
  parameter int SDISP_W = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SEG_W-1:0]       seg_cs,
  input  logic [SEG_W-1:0]       seg_ds,
  input  logic [SEG_W-1:0]       seg_ss,
  input  logic [SEG_W-1:0]       seg_es,
  input  logic [OFS_W-1:0]       reg_bx,
  input  logic [OFS_W-1:0]       reg_bp,
  input  logic [OFS_W-1:0]       reg_si,
  input  logic [OFS_W-1:0]       reg_di,
  input  logic [OFS_W-1:0]       ip,
  input  logic [2:0]             mode,
  input  logic [1:0]             ptr_sel,
  input  logic                   base_sel,
  input  logic                   idx_sel,
  input  logic [OFS_W-1:0]       disp,
  input  logic [1:0]             disp_kind,
  input  logic [1:0]             acc,
  input  logic                   ovr_en,
  input  logic [1:0]             ovr_seg,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OFS_W-1:0]       eff_ofs,
  output logic [1:0]             seg_id,
  output logic [SEG_W-1:0]       seg_val,
  output logic [SEG_W+SHIFT-1:0] phys
);
  localparam int PA_W  = SEG_W + SHIFT;
  localparam int PAY_W = OFS_W + 2 + SEG_W + PA_W;

  logic [OFS_W-1:0] c_ofs;
  logic             c_bp;
  logic [1:0]       c_id;
  logic [SEG_W-1:0] c_seg;
  logic [PA_W-1:0]  c_phys;
  logic [PAY_W-1:0] pay_in, pay_out;

  agu_offset #(.OFS_W(OFS_W), .SDISP_W(SDISP_W)) ofs_i (
    .acc(acc), .mode(mode), .ptr_sel(ptr_sel), .base_sel(base_sel),
    .idx_sel(idx_sel), .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
    .ip(ip), .disp(disp), .disp_kind(disp_kind), .ofs(c_ofs), .bp_base(c_bp)
  );

  agu_segsel #(.SEG_W(SEG_W)) seg_i (
    .acc(acc), .ovr_en(ovr_en), .ovr_seg(ovr_seg), .bp_base(c_bp),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .seg_id(c_id), .seg_val(c_seg)
  );

  agu_combine #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) add_i (
    .seg_val(c_seg), .ofs(c_ofs), .phys(c_phys)
  );

  assign pay_in = {c_ofs, c_id, c_seg, c_phys};

  agu_outreg #(.W(PAY_W), .OUT_REG(OUT_REG)) out_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(pay_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(pay_out)
  );

  assign {eff_ofs, seg_id, seg_val, phys} = pay_out;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W   = 16,
  parameter int OFS_W   = 16,
  parameter int SHIFT   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [1:0]             acc,
  input logic [OFS_W-1:0]       ip,
  input logic [SEG_W-1:0]       seg_cs,
  input logic [OFS_W-1:0]       eff_ofs,
  input logic [1:0]             seg_id,
  input logic [SEG_W-1:0]       seg_val,
  input logic [SEG_W+SHIFT-1:0] phys
);
  localparam int PA_W = SEG_W + SHIFT;

  logic [PA_W-1:0] sum_chk;
  assign sum_chk = (PA_W'(seg_val) << SHIFT) + PA_W'(eff_ofs);

  p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (phys == sum_chk));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  generate
    if (OUT_REG) begin : g_seq
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
          (out_valid && $stable(phys) && $stable(eff_ofs) && $stable(seg_id)));

      p_fetch_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && acc == 2'd0) |=>
          (out_valid && seg_id == 2'd1 && eff_ofs == $past(ip)
           && seg_val == $past(seg_cs)));
    end else begin : g_comb
      p_fetch_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc == 2'd0) |->
          (seg_id == 2'd1 && eff_ofs == ip && seg_val == seg_cs));
    end
  endgenerate
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .OUT_REG(OUT_REG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .acc(acc), .ip(ip),
  .seg_cs(seg_cs), .eff_ofs(eff_ofs), .seg_id(seg_id), .seg_val(seg_val),
  .phys(phys)
);

// File: tb/seg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] seg_cs, seg_ds, seg_ss, seg_es;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di, ip, disp;
  logic [2:0]  mode;
  logic [1:0]  ptr_sel, disp_kind, acc, ovr_seg;
  logic        base_sel, idx_sel, ovr_en;
  logic [15:0] eff_ofs, seg_val;
  logic [1:0]  seg_id;
  logic [19:0] phys;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .seg_cs(seg_cs), .seg_ds(seg_ds), .seg_ss(seg_ss), .seg_es(seg_es),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .ip(ip), .mode(mode), .ptr_sel(ptr_sel), .base_sel(base_sel),
    .idx_sel(idx_sel), .disp(disp), .disp_kind(disp_kind), .acc(acc),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg), .out_valid(out_valid),
    .out_ready(out_ready), .eff_ofs(eff_ofs), .seg_id(seg_id),
    .seg_val(seg_val), .phys(phys)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] e_ofs, e_val;
  logic [1:0]  e_id;
  logic [19:0] e_phys;
  string       t_ofs, t_seg;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    int d, s;
    logic bpb;
    if (disp_kind == 2'd0) d = 0;
    else if (disp_kind == 2'd1) d = int'(disp[7:0]) - (disp[7] ? 256 : 0);
    else d = int'(disp);
    bpb = 1'b0;
    t_ofs = "R3";
    if (acc == 2'd0) begin
      s = int'(ip); t_ofs = "R2";
    end else begin
      case (mode)
        3'd1: begin
          s = (ptr_sel == 0) ? int'(reg_bx) : (ptr_sel == 1) ? int'(reg_bp) :
              (ptr_sel == 2) ? int'(reg_si) : int'(reg_di);
          bpb = (ptr_sel == 1);
        end
        3'd2: begin
          s = (base_sel ? int'(reg_bp) : int'(reg_bx)) + d;
          bpb = base_sel; t_ofs = "R4";
        end
        3'd3: begin
          s = (idx_sel ? int'(reg_di) : int'(reg_si)) + d; t_ofs = "R4";
        end
        3'd4: begin
          s = (base_sel ? int'(reg_bp) : int'(reg_bx))
            + (idx_sel ? int'(reg_di) : int'(reg_si)) + d;
          bpb = base_sel; t_ofs = "R4";
        end
        3'd0: s = int'(disp);
        default: begin s = int'(disp); t_ofs = "R8"; end
      endcase
    end
    e_ofs = s[15:0];
    if (acc == 2'd0) begin e_id = 2'd1; t_seg = "R2"; end
    else if (ovr_en) begin e_id = ovr_seg; t_seg = "R7"; end
    else if (acc == 2'd2 || bpb) begin e_id = 2'd2; t_seg = "R6"; end
    else begin e_id = 2'd3; t_seg = (acc == 2'd3) ? "R8" : "R6"; end
    e_val = (e_id == 0) ? seg_es : (e_id == 1) ? seg_cs :
            (e_id == 2) ? seg_ss : seg_ds;
    s = (int'(e_val) * 16 + int'(e_ofs)) % (1 << 20);
    e_phys = s[19:0];
  endtask

  task automatic rand_regs();
    seg_cs = 16'($urandom); seg_ds = 16'($urandom);
    seg_ss = 16'($urandom); seg_es = 16'($urandom);
    reg_bx = 16'($urandom); reg_bp = 16'($urandom);
    reg_si = 16'($urandom); reg_di = 16'($urandom);
    ip = 16'($urandom); disp = 16'($urandom);
  endtask

  task automatic check_all();
    chk("R9", "out_valid", 32'(out_valid), 32'd1);
    chk(t_ofs, "eff_ofs", 32'(eff_ofs), 32'(e_ofs));
    chk(t_seg, "seg_id", 32'(seg_id), 32'(e_id));
    chk(t_seg, "seg_val", 32'(seg_val), 32'(e_val));
    chk("R1", "phys", 32'(phys), 32'(e_phys));
  endtask

  initial begin
    logic [15:0] h_ofs; logic [19:0] h_phys;
    in_valid = 0; out_ready = 1;
    mode = 0; ptr_sel = 0; base_sel = 0; idx_sel = 0; disp_kind = 0;
    acc = 1; ovr_en = 0; ovr_seg = 0;
    rand_regs();
    repeat (3) @(negedge clk);
    chk("R10", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R10", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "out_valid after reset", 32'(out_valid), 32'd0);

    // Sweep of every control combination with random register contents
    in_valid = 1;
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 4; p++)
        for (int b = 0; b < 2; b++)
          for (int x = 0; x < 2; x++)
            for (int k = 0; k < 4; k++)
              for (int a = 0; a < 4; a++)
                for (int oe = 0; oe < 2; oe++)
                  for (int os = 0; os < 4; os++) begin
                    mode = 3'(m); ptr_sel = 2'(p); base_sel = b[0];
                    idx_sel = x[0]; disp_kind = 2'(k); acc = 2'(a);
                    ovr_en = oe[0]; ovr_seg = 2'(os);
                    rand_regs();
                    model();
                    @(negedge clk);
                    check_all();
                  end

    // R5: offset wrap, base + index + short negative displacement
    mode = 3'd4; base_sel = 0; idx_sel = 0; disp_kind = 2'd1; acc = 2'd1;
    ovr_en = 0; reg_bx = 16'hFFF0; reg_si = 16'h0020; disp = 16'h0005;
    model(); @(negedge clk);
    chk("R5", "eff_ofs wrap", 32'(eff_ofs), 32'h0015);
    reg_bx = 16'h0003; reg_si = 16'h0001; disp = 16'h00F8;
    model(); @(negedge clk);
    chk("R5", "eff_ofs sext wrap", 32'(eff_ofs), 32'hFFFC);

    // R1: physical address wrap at 2^20
    mode = 3'd0; disp = 16'hFFFF; seg_ds = 16'hFFFF;
    model(); @(negedge clk);
    chk("R1", "phys wrap", 32'(phys), 32'h0FFEF);

    // R9: back-pressure holds the result and blocks input
    mode = 3'd0; acc = 2'd1; disp = 16'h1234; seg_ds = 16'h2000;
    model(); h_ofs = e_ofs; h_phys = e_phys;
    @(negedge clk);
    out_ready = 0;
    disp = 16'h0042;
    #1;
    chk("R9", "in_ready stalled", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R9", "held eff_ofs", 32'(eff_ofs), 32'(h_ofs));
    chk("R9", "held phys", 32'(phys), 32'(h_phys));
    chk("R9", "held out_valid", 32'(out_valid), 32'd1);
    out_ready = 1;
    model();
    #1;
    chk("R9", "in_ready released", 32'(in_ready), 32'd1);
    @(negedge clk);
    chk("R9", "queued eff_ofs", 32'(eff_ofs), 32'h0042);
    chk("R9", "queued phys", 32'(phys), 32'(e_phys));
    in_valid = 0;
    @(negedge clk);
    chk("R9", "out_valid drained", 32'(out_valid), 32'd0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule